// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block takes a received frame's 48-bit destination address one byte per accepted cycle and decides whether a group-addressed frame passes. It runs an Ethernet CRC-32 over the six address bytes as they arrive. It bit-reverses the complemented result and takes the top eight bits as an index into a 256-bit lookup table. The table is supplied as eight 32-bit words. The indexed bit gives the verdict.

A frame counts as multicast when bit 0 of its first address byte is set. For unicast frames the block raises a not-applicable flag instead of a verdict, leaving the choice to whatever perfect-match logic sits beside it. A pass-all-multicast control accepts every group-addressed frame without consulting the table. The result appears with a one-cycle done strobe right after the final address byte is taken. Idle cycles between bytes are allowed. A fresh start marker always begins a new address.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash index is computed over the six address bytes in arrival order with polynomial 0x04C11DB7, register preset to all ones, and each byte fed least significant bit first. The final register value is complemented and then bit-reversed, and the index is the upper eight bits of the reversed value.
- R2: Index bits [7:5] pick the table word and bits [4:0] pick the bit inside it. Word w sits at hash_table[32*w+31:32*w], so index 8'hBF addresses bit 31 of word 5 (hash_table[191]).
- R3: For a multicast address with pass_all_mcast low, accept equals the indexed table bit.
- R4: With pass_all_mcast high when the last byte is taken, every multicast address gives accept = 1 whatever the table holds.
- R5: An address whose first byte has bit 0 clear gives done = 1, not_applicable = 1 and accept = 0. For a multicast address not_applicable = 0.
- R6: done, accept and not_applicable appear in the cycle after the clock edge that takes the sixth byte. done lasts exactly one cycle. Cycles with addr_valid low between bytes are skipped without effect on the result.
- R7: A byte taken with addr_start high always begins a new address as its first byte and discards any partly received address.
- R8: Bytes with addr_valid high and addr_start low that arrive when no address is in progress produce no done and do not disturb the next address.
- R9: While rst_n is low at a clock edge, done, accept and not_applicable are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_byte | input | 8 | Destination address byte, first byte first |
| addr_valid | input | 1 | addr_byte is valid this cycle |
| addr_start | input | 1 | This valid byte is the first address byte |
| hash_table | input | 256 | Lookup table, word w in bits [32w+31:32w] |
| pass_all_mcast | input | 1 | Accept all multicast addresses |
| done | output | 1 | One-cycle strobe: decision outputs valid |
| accept | output | 1 | Frame accepted (valid with done) |
| not_applicable | output | 1 | Unicast address, no hash verdict (valid with done) |

## Verification
The assertions check the timing relations on every cycle. done is always a single-cycle pulse that follows a valid input byte. not_applicable never coexists with accept. A pass-all setting in the final byte's cycle forces acceptance, and reset clears the outputs. The position counter also never runs past the address length. Whether the index is the correct reversed CRC and picks the correct word and bit can only be shown by the bench's scenarios. The same holds for correct restart on a new start marker and for stray bytes being ignored. The bench compares these against a separately written reference CRC and table model.

// File: rtl/mhf_pkg.sv
// Package: shared constants and types for the multicast hash filter.
// Assumes a 32-bit CRC processed in reflected (LSB-first) form.
package mhf_pkg;
    localparam int          CRC_W         = 32;
    // Reflected form of the polynomial 0x04C11DB7
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

    typedef struct packed {
        logic done;
        logic accept;
        logic not_app;
    } mhf_result_t;
endpackage

// File: rtl/mhf_crc_step.sv
// Module: one-byte combinational CRC update in reflected form.
// Does: shifts DATA_W input bits, LSB first, through the CRC register.
// Assumes: POLY_REFL is the bit-reversed generator polynomial.
module mhf_crc_step #(
    parameter int                 DATA_W    = 8,
    parameter int                 CRC_W     = 32,
    parameter logic [CRC_W-1:0]   POLY_REFL = 32'hEDB8_8320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [DATA_W:0][CRC_W-1:0] stage;

    assign stage[0] = crc_in;

    // one shift-and-conditional-xor per input bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign stage[i+1] = (stage[i][0] ^ data_in[i])
                          ? ((stage[i] >> 1) ^ POLY_REFL)
                          : (stage[i] >> 1);
    end

    assign crc_out = stage[DATA_W];
endmodule

// File: rtl/mhf_addr_seq.sv
// Module: address byte sequencer with running CRC.
// Does: counts address bytes, keeps the CRC and the multicast flag, and flags
// the cycle in which the final byte is taken.
// Assumes: a byte with addr_start high always restarts; bytes without start are
// taken only while an address is in progress.
module mhf_addr_seq #(
    parameter int ADDR_BYTES = 6,
    parameter int CRC_W      = mhf_pkg::CRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       byte_in,
    input  logic             valid_in,
    input  logic             start_in,
    output logic             last_byte,
    output logic             mcast_now,
    output logic [CRC_W-1:0] crc_next
);
    localparam int               CNT_W    = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_PEN  = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q;
    logic             mcast_q;
    logic             take;
    logic [CRC_W-1:0] crc_base;

    // decide whether this cycle's byte belongs to an address
    always_comb begin
        take      = valid_in && (start_in || (cnt_q != '0 && cnt_q != CNT_FULL));
        crc_base  = start_in ? mhf_pkg::CRC_PRESET : crc_q;
        mcast_now = start_in ? byte_in[0] : mcast_q;
        last_byte = take && (start_in ? (ADDR_BYTES == 1) : (cnt_q == CNT_PEN));
    end

    mhf_crc_step #(
        .DATA_W    (8),
        .CRC_W     (CRC_W),
        .POLY_REFL (mhf_pkg::CRC_POLY_REFL)
    ) u_step (
        .crc_in  (crc_base),
        .data_in (byte_in),
        .crc_out (crc_next)
    );

    // advance position, CRC and multicast flag on each taken byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            crc_q   <= mhf_pkg::CRC_PRESET;
            mcast_q <= 1'b0;
        end else if (take) begin
            cnt_q   <= start_in ? CNT_W'(1) : cnt_q + CNT_W'(1);
            crc_q   <= crc_next;
            mcast_q <= mcast_now;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    // R7
    restart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && start_in) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/mhf_hash_lookup.sv
// Module: hash index extraction and table bit selection.
// Does: complements the reflected CRC (which equals the bit-reversed standard
// CRC), takes its top index bits and reads the selected table bit.
// Assumes: TABLE_WORDS and WORD_BITS are powers of two.
module mhf_hash_lookup #(
    parameter int TABLE_WORDS = 8,
    parameter int WORD_BITS   = 32,
    parameter int CRC_W       = mhf_pkg::CRC_W
) (
    input  logic [CRC_W-1:0]                 crc_refl,
    input  logic [TABLE_WORDS*WORD_BITS-1:0] table_in,
    output logic                             hit
);
    localparam int WSEL_W = $clog2(TABLE_WORDS);
    localparam int BSEL_W = $clog2(WORD_BITS);
    localparam int IDX_W  = WSEL_W + BSEL_W;

    logic [WORD_BITS-1:0] words [TABLE_WORDS];
    logic [CRC_W-1:0]     crc_fin;
    logic [IDX_W-1:0]     idx;
    logic [WSEL_W-1:0]    word_sel;
    logic [BSEL_W-1:0]    bit_sel;

    // split the flat table into words
    for (genvar w = 0; w < TABLE_WORDS; w++) begin : g_word
        assign words[w] = table_in[w*WORD_BITS +: WORD_BITS];
    end

    // form the index and pick the table bit
    always_comb begin
        crc_fin  = ~crc_refl;
        idx      = crc_fin[CRC_W-1 -: IDX_W];
        word_sel = idx[IDX_W-1 -: WSEL_W];
        bit_sel  = idx[BSEL_W-1:0];
        hit      = words[word_sel][bit_sel];
    end
endmodule

// File: rtl/mcast_hash_filter.sv
// Module: multicast destination address hash filter (top).
// Does: hashes a byte-serial destination address and registers the
// accept / not-applicable decision with a done strobe one cycle after the
// final byte.
// Assumes: ADDR_BYTES > 1; pass_all_mcast and hash_table are sampled in the
// cycle the final byte is taken.
module mcast_hash_filter #(
    parameter int ADDR_BYTES  = 6,
    parameter int TABLE_WORDS = 8,
    parameter int WORD_BITS   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [7:0]                       addr_byte,
    input  logic                             addr_valid,
    input  logic                             addr_start,
    input  logic [TABLE_WORDS*WORD_BITS-1:0] hash_table,
    input  logic                             pass_all_mcast,
    output logic                             done,
    output logic                             accept,
    output logic                             not_applicable
);
    localparam int CRC_W = mhf_pkg::CRC_W;

    logic                last_byte;
    logic                mcast_now;
    logic [CRC_W-1:0]    crc_next;
    logic                hit;
    mhf_pkg::mhf_result_t res_q;

    mhf_addr_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .CRC_W      (CRC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (addr_byte),
        .valid_in  (addr_valid),
        .start_in  (addr_start),
        .last_byte (last_byte),
        .mcast_now (mcast_now),
        .crc_next  (crc_next)
    );

    mhf_hash_lookup #(
        .TABLE_WORDS (TABLE_WORDS),
        .WORD_BITS   (WORD_BITS),
        .CRC_W       (CRC_W)
    ) u_lookup (
        .crc_refl (crc_next),
        .table_in (hash_table),
        .hit      (hit)
    );

    // register the decision in the cycle the final byte is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q.done    <= last_byte;
            res_q.accept  <= last_byte && mcast_now && (pass_all_mcast || hit);
            res_q.not_app <= last_byte && !mcast_now;
        end
    end

    assign done           = res_q.done;
    assign accept         = res_q.accept;
    assign not_applicable = res_q.not_app;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(addr_valid));

    // R4
    pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !not_applicable && $past(pass_all_mcast)) |-> accept);

    // R5
    unicast_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_applicable |-> (done && !accept));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !accept && !not_applicable));
endmodule

// File: tb/mcast_hash_filter_tb_top.sv
// Bench: random and directed addresses checked against a reference CRC model.
module mcast_hash_filter_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr_byte = '0;
    logic         addr_valid = 1'b0;
    logic         addr_start = 1'b0;
    logic [255:0] hash_table;
    logic         pass_all_mcast = 1'b0;
    logic         done, accept, not_applicable;

    logic [31:0]  tw [8];
    int           n_run = 0;
    int           n_fail = 0;
    bit           finished = 0;

    always #2.5 clk = ~clk;

    always_comb hash_table = {tw[7], tw[6], tw[5], tw[4], tw[3], tw[2], tw[1], tw[0]};

    mcast_hash_filter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .addr_byte      (addr_byte),
        .addr_valid     (addr_valid),
        .addr_start     (addr_start),
        .hash_table     (hash_table),
        .pass_all_mcast (pass_all_mcast),
        .done           (done),
        .accept         (accept),
        .not_applicable (not_applicable)
    );

    // reference index: MSB-first CRC, complement, reverse, upper 8 bits (R1)
    function automatic logic [7:0] ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] r;
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 8; i++) begin
                logic fb = c[31] ^ a[8*k + i];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        c = ~c;
        for (int i = 0; i < 32; i++) r[31-i] = c[i];
        return r[31:24];
    endfunction

    // expected {done, accept, not_applicable} per R2..R5
    function automatic logic [2:0] ref_result(input logic [47:0] a, input logic pass);
        logic [7:0] ix = ref_index(a);
        logic mc = a[0];
        logic bitv = tw[ix[7:5]][ix[4:0]];
        return {1'b1, mc && (pass || bitv), !mc};
    endfunction

    task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {done,accept,na} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            addr_valid = 1'b0;
            addr_start = 1'b0;
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic st);
        @(negedge clk);
        addr_byte  = b;
        addr_valid = 1'b1;
        addr_start = st;
    endtask

    // send one address (first byte at a[7:0]) with random gaps, check result
    task automatic run_addr(input logic [47:0] a, input int gap_max, input string tag);
        logic [2:0] exp;
        for (int k = 0; k < 6; k++) begin
            if (k > 0 && gap_max > 0) idle($urandom % (gap_max + 1));
            put_byte(a[8*k +: 8], k == 0);
        end
        exp = ref_result(a, pass_all_mcast);
        @(negedge clk);
        addr_valid = 1'b0;
        addr_start = 1'b0;
        #1;
        check3({done, accept, not_applicable}, exp, tag);
        @(negedge clk);
        #1;
        check3({done, accept, not_applicable}, 3'b000, {tag, " R6 pulse end"});
    endtask

    function automatic logic [47:0] rand_addr(input logic mc);
        logic [47:0] a = {$urandom, $urandom};
        a[0] = mc;
        return a;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] a;
        logic [47:0] b;
        void'($urandom(32'd20240611));
        for (int w = 0; w < 8; w++) tw[w] = $urandom;

        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        check3({done, accept, not_applicable}, 3'b000, "R9 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R8: stray bytes after reset, no address open
        for (int k = 0; k < 4; k++) begin
            put_byte(8'($urandom), 1'b0);
            #1;
            check3({done, accept, not_applicable}, 3'b000, "R8 stray after reset");
        end
        idle(2);
        check3({done, accept, not_applicable}, 3'b000, "R8 stray after reset tail");

        // R1 R3 R6: random multicast addresses, random tables and gaps
        for (int n = 0; n < 150; n++) begin
            if (n % 10 == 0) for (int w = 0; w < 8; w++) tw[w] = $urandom;
            run_addr(rand_addr(1'b1), (n % 3 == 0) ? 3 : 0, "R1 R3 R6 random mcast");
        end

        // R5: unicast addresses
        for (int n = 0; n < 20; n++) run_addr(rand_addr(1'b0), 1, "R5 unicast");

        // R2: single-bit table at the computed index, then the inverse table
        a = rand_addr(1'b1);
        for (int w = 0; w < 8; w++) tw[w] = '0;
        tw[ref_index(a) >> 5][ref_index(a) & 8'h1F] = 1'b1;
        run_addr(a, 0, "R2 single bit set");
        for (int w = 0; w < 8; w++) tw[w] = '1;
        tw[ref_index(a) >> 5][ref_index(a) & 8'h1F] = 1'b0;
        run_addr(a, 0, "R2 single bit clear");

        // R2: index 8'hBF maps to word 5 bit 31 (hash_table[191])
        for (int w = 0; w < 8; w++) tw[w] = '0;
        tw[5][31] = 1'b1;
        b = '0;
        for (int t = 0; t < 20000; t++) begin
            a = rand_addr(1'b1);
            if (ref_index(a) == 8'hBF) begin
                b = a;
                break;
            end
        end
        if (b != '0) begin
            @(negedge clk);
            run_addr(b, 0, "R2 index BF word5 bit31");
        end

        // R4: pass-all with empty table; unicast still not applicable
        for (int w = 0; w < 8; w++) tw[w] = '0;
        pass_all_mcast = 1'b1;
        for (int n = 0; n < 10; n++) run_addr(rand_addr(1'b1), 2, "R4 pass all mcast");
        run_addr(rand_addr(1'b0), 0, "R4 R5 pass all unicast");
        pass_all_mcast = 1'b0;
        run_addr(rand_addr(1'b1), 0, "R3 empty table rejects");

        // R7: partial address abandoned by a new start
        for (int w = 0; w < 8; w++) tw[w] = $urandom;
        for (int n = 0; n < 10; n++) begin
            a = rand_addr($urandom % 2);
            for (int k = 0; k < 1 + n % 5; k++) put_byte(a[8*k +: 8], k == 0);
            #1;
            check3({done, accept, not_applicable}, 3'b000, "R7 partial no done");
            run_addr(rand_addr($urandom % 2), n % 2, "R7 restart");
        end

        // R8: stray bytes after a completed address, then a clean address
        for (int n = 0; n < 5; n++) begin
            for (int k = 0; k < 3; k++) begin
                put_byte(8'($urandom), 1'b0);
                #1;
                check3({done, accept, not_applicable}, 3'b000, "R8 stray after address");
            end
            run_addr(rand_addr(1'b1), 0, "R8 next address intact");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule